// File: doc/BRIEF.md
# Virtual-Channel Router Input Port Controller

This block is the control logic of one input port of a virtual-channel router in a two-dimensional mesh network-on-chip. Flits arrive on the port with a type field and a virtual-channel number. Each virtual channel has its own small flit queue and its own state machine. A packet's opening flit passes through four stages: route computation, output-VC allocation, switch allocation and switch traversal. The flits that follow it in the same channel skip the first two stages and use the route and output VC that the opening flit obtained. They leave in order, one switch-allocation win at a time.

The VC allocator, the switch allocator and the crossbar sit outside the block. The block raises one VC-allocation request and one switch-allocation request per input VC, with the output port it wants. It takes in one-hot grants and registers the winning flit toward the crossbar. Each flit that leaves returns one credit upstream. The flit that closes a packet also returns the output VC it held.

Top module: `vcr_input_port`

## Requirements
- R1: An opening flit written into an empty, idle VC at clock edge n, with VC and switch grants given as soon as they are requested, appears on the traversal outputs after edge n+4. The stages are: idle detect at n+1, route registered at n+2, VC grant at n+3, switch win at n+4.
- R2: Dimension-order routing. The destination X is flit data bits 3:0 and the destination Y is bits 7:4. X is resolved before Y. The port codes are: 0 for the local port, 1 toward larger Y, 2 toward larger X, 3 toward smaller Y, 4 toward smaller X. The code is shown on the request port field of the VC once routing is done.
- R3: Only flits of type 01 (head) or 11 (single-flit packet) start routing and VC allocation. A VC's allocation request stays high until its grant, and the granted output VC is captured at that grant. Body (00) and tail (10) flits use only switch allocation. A VC never requests both allocators in the same cycle.
- R4: A VC requests switch allocation whenever it holds a flit and owns an output VC. A VC that loses keeps its request and its flit and is served again later. A switch grant to a VC that is not requesting has no effect. At most one switch grant is given per cycle.
- R5: Flits of one VC leave in the order they arrived. On the traversal output, the flit's type and data appear together with the stored output port and output VC.
- R6: When a tail (10) or single-flit (11) flit traverses, a release pulse carries its output port and output VC in the same cycle as the flit. The input VC then goes idle, and a following opening flit in that VC starts route computation.
- R7: Every flit that traverses returns one credit, tagged with its input VC, in the same cycle as the flit. No credit is returned while switch allocation is withheld.
- R8: While reset is low, the allocation requests, the traversal valid, the credit and the release outputs are all low.
- R9: Each VC buffers four flits. Four flits are accepted into a VC with no traversal, and a write into a full VC never happens while the upstream respects credits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flit_valid_i | input | 1 | Incoming flit valid |
| flit_vc_i | input | VC_W | Input VC of the incoming flit |
| flit_type_i | input | 2 | Flit type: 00 body, 01 head, 10 tail, 11 single |
| flit_data_i | input | FLIT_W | Flit payload; bits 7:0 hold the destination in opening flits |
| credit_valid_o | output | 1 | One buffer slot freed |
| credit_vc_o | output | VC_W | VC of the freed slot |
| va_req_o | output | NUM_VC | VC-allocation request per input VC |
| va_gnt_i | input | NUM_VC | VC-allocation grant per input VC |
| va_ovc_i | input | VC_W | Output VC given with the grant |
| sa_req_o | output | NUM_VC | Switch-allocation request per input VC |
| sa_gnt_i | input | NUM_VC | Switch-allocation grant, one-hot or zero |
| req_port_o | output | 3*NUM_VC | Routed output port per input VC |
| out_valid_o | output | 1 | Flit on the crossbar output |
| out_port_o | output | 3 | Output port of that flit |
| out_vc_o | output | VC_W | Output VC of that flit |
| out_type_o | output | 2 | Type of that flit |
| out_data_o | output | FLIT_W | Payload of that flit |
| vc_free_o | output | 1 | Output VC released |
| vc_free_port_o | output | 3 | Port of the released VC |
| vc_free_vc_o | output | VC_W | Index of the released VC |

## Verification
A multi-flit packet is first sent alone with eager grants. This separates correct stage latency from an extra or a missing pipeline step. Single-flit packets aimed at each of the five directions tell the X-before-Y order and each port code apart. A phase that withholds switch grants until both queues fill shows whether losers keep their flits and requests, and whether credits stop. Mixed traffic on both VCs then adds random allocator refusals and stray switch grants to idle VCs. This exposes reordering, leaks between VCs, and releases on the wrong flit.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  typedef enum logic [1:0] {
    VC_IDLE   = 2'd0,
    VC_ROUTE  = 2'd1,
    VC_WAIT   = 2'd2,
    VC_ACTIVE = 2'd3
  } vc_state_e;

  localparam int PORT_W  = 3;
  localparam int TYPE_W  = 2;
  localparam int COORD_W = 4;

  localparam logic [PORT_W-1:0] PORT_LOCAL = 3'd0;
  localparam logic [PORT_W-1:0] PORT_NORTH = 3'd1;
  localparam logic [PORT_W-1:0] PORT_EAST  = 3'd2;
  localparam logic [PORT_W-1:0] PORT_SOUTH = 3'd3;
  localparam logic [PORT_W-1:0] PORT_WEST  = 3'd4;

  // type bit 0: opens a packet, bit 1: closes a packet
  function automatic logic [PORT_W-1:0] xy_route(
    input logic [COORD_W-1:0] dst_x, input logic [COORD_W-1:0] dst_y,
    input logic [COORD_W-1:0] here_x, input logic [COORD_W-1:0] here_y);
    if (dst_x > here_x)      return PORT_EAST;
    else if (dst_x < here_x) return PORT_WEST;
    else if (dst_y > here_y) return PORT_NORTH;
    else if (dst_y < here_y) return PORT_SOUTH;
    else                     return PORT_LOCAL;
  endfunction
endpackage

// File: rtl/vcr_vc_fifo.sv
module vcr_vc_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign empty_o = (count == '0);
  assign full_o  = (count == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/vcr_vc_ctrl.sv
module vcr_vc_ctrl
  import vcr_pkg::*;
#(
  parameter int                 VC_W   = 1,
  parameter logic [COORD_W-1:0] HERE_X = 4'd2,
  parameter logic [COORD_W-1:0] HERE_Y = 4'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              front_valid_i,
  input  logic [TYPE_W-1:0] front_type_i,
  input  logic [7:0]        front_dest_i,
  input  logic              va_gnt_i,
  input  logic [VC_W-1:0]   va_ovc_i,
  input  logic              sa_win_i,
  output logic              va_req_o,
  output logic              sa_req_o,
  output logic [PORT_W-1:0] port_o,
  output logic [VC_W-1:0]   ovc_o
);
  vc_state_e         state_q;
  logic [PORT_W-1:0] port_q;
  logic [VC_W-1:0]   ovc_q;

  assign va_req_o = (state_q == VC_WAIT);
  assign sa_req_o = (state_q == VC_ACTIVE) && front_valid_i;
  assign port_o   = port_q;
  assign ovc_o    = ovc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= VC_IDLE;
      port_q  <= PORT_LOCAL;
      ovc_q   <= '0;
    end else begin
      unique case (state_q)
        VC_IDLE:   if (front_valid_i && front_type_i[0]) state_q <= VC_ROUTE;
        VC_ROUTE: begin
          port_q  <= xy_route(front_dest_i[3:0], front_dest_i[7:4], HERE_X, HERE_Y);
          state_q <= VC_WAIT;
        end
        VC_WAIT: if (va_gnt_i) begin
          ovc_q   <= va_ovc_i;
          state_q <= VC_ACTIVE;
        end
        VC_ACTIVE: if (sa_win_i && front_type_i[1]) state_q <= VC_IDLE;
        default:   state_q <= VC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vcr_input_port.sv
module vcr_input_port
  import vcr_pkg::*;
#(
  parameter int                 NUM_VC     = 2,
  parameter int                 FIFO_DEPTH = 4,
  parameter int                 FLIT_W     = 16,
  parameter logic [COORD_W-1:0] HERE_X     = 4'd2,
  parameter logic [COORD_W-1:0] HERE_Y     = 4'd2,
  localparam int                VC_W       = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flit_valid_i,
  input  logic [VC_W-1:0]          flit_vc_i,
  input  logic [TYPE_W-1:0]        flit_type_i,
  input  logic [FLIT_W-1:0]        flit_data_i,
  output logic                     credit_valid_o,
  output logic [VC_W-1:0]          credit_vc_o,
  output logic [NUM_VC-1:0]        va_req_o,
  input  logic [NUM_VC-1:0]        va_gnt_i,
  input  logic [VC_W-1:0]          va_ovc_i,
  output logic [NUM_VC-1:0]        sa_req_o,
  input  logic [NUM_VC-1:0]        sa_gnt_i,
  output logic [PORT_W*NUM_VC-1:0] req_port_o,
  output logic                     out_valid_o,
  output logic [PORT_W-1:0]        out_port_o,
  output logic [VC_W-1:0]          out_vc_o,
  output logic [TYPE_W-1:0]        out_type_o,
  output logic [FLIT_W-1:0]        out_data_o,
  output logic                     vc_free_o,
  output logic [PORT_W-1:0]        vc_free_port_o,
  output logic [VC_W-1:0]          vc_free_vc_o
);
  localparam int ENTRY_W = FLIT_W + TYPE_W;

  logic [ENTRY_W-1:0] front    [NUM_VC];
  logic [PORT_W-1:0]  port_all [NUM_VC];
  logic [VC_W-1:0]    ovc_all  [NUM_VC];
  logic [NUM_VC-1:0]  vc_empty, vc_full, sa_win;
  logic               sel_hit;
  logic [VC_W-1:0]    sel_idx;
  logic [ENTRY_W-1:0] sel_entry;

  assign sa_win = sa_gnt_i & sa_req_o;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic push;
    assign push = flit_valid_i && (flit_vc_i == VC_W'(v));

    vcr_vc_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push),
      .din_i   ({flit_type_i, flit_data_i}),
      .pop_i   (sa_win[v]),
      .dout_o  (front[v]),
      .empty_o (vc_empty[v]),
      .full_o  (vc_full[v])
    );

    vcr_vc_ctrl #(.VC_W(VC_W), .HERE_X(HERE_X), .HERE_Y(HERE_Y)) u_ctrl (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .front_valid_i (!vc_empty[v]),
      .front_type_i  (front[v][ENTRY_W-1 -: TYPE_W]),
      .front_dest_i  (front[v][7:0]),
      .va_gnt_i      (va_gnt_i[v]),
      .va_ovc_i      (va_ovc_i),
      .sa_win_i      (sa_win[v]),
      .va_req_o      (va_req_o[v]),
      .sa_req_o      (sa_req_o[v]),
      .port_o        (port_all[v]),
      .ovc_o         (ovc_all[v])
    );

    assign req_port_o[v*PORT_W +: PORT_W] = port_all[v];
  end

  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      if (sa_win[v] && !sel_hit) begin
        sel_hit = 1'b1;
        sel_idx = VC_W'(v);
      end
    end
  end

  assign sel_entry = front[sel_idx];

  // switch traversal register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o    <= 1'b0;
      out_port_o     <= '0;
      out_vc_o       <= '0;
      out_type_o     <= '0;
      out_data_o     <= '0;
      credit_valid_o <= 1'b0;
      credit_vc_o    <= '0;
      vc_free_o      <= 1'b0;
    end else begin
      out_valid_o    <= sel_hit;
      credit_valid_o <= sel_hit;
      credit_vc_o    <= sel_idx;
      vc_free_o      <= sel_hit && sel_entry[ENTRY_W-1];
      if (sel_hit) begin
        out_port_o <= port_all[sel_idx];
        out_vc_o   <= ovc_all[sel_idx];
        out_type_o <= sel_entry[ENTRY_W-1 -: TYPE_W];
        out_data_o <= sel_entry[FLIT_W-1:0];
      end
    end
  end

  assign vc_free_port_o = out_port_o;
  assign vc_free_vc_o   = out_vc_o;
endmodule

// File: rtl/vcr_checker.sv
module vcr_checker #(
  parameter int NUM_VC = 2,
  parameter int VC_W   = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flit_valid_i,
  input logic [VC_W-1:0]   flit_vc_i,
  input logic [NUM_VC-1:0] vc_full,
  input logic [NUM_VC-1:0] va_req_o,
  input logic [NUM_VC-1:0] va_gnt_i,
  input logic [NUM_VC-1:0] sa_req_o,
  input logic [NUM_VC-1:0] sa_gnt_i,
  input logic              out_valid_o,
  input logic [1:0]        out_type_o,
  input logic              credit_valid_o,
  input logic              vc_free_o
);
  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flit_valid_i |-> !vc_full[flit_vc_i]);

  assert_gnt_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sa_gnt_i));

  assert_traverse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sa_gnt_i & sa_req_o)) |=> out_valid_o);

  assert_credit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sa_gnt_i & sa_req_o)) |=> credit_valid_o);

  assert_no_credit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(sa_gnt_i & sa_req_o)) |=> !credit_valid_o);

  assert_free_tail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vc_free_o |-> (out_valid_o && out_type_o[1]));

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    assert_sa_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sa_req_o[v] && !sa_gnt_i[v]) |=> sa_req_o[v]);
    assert_va_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (va_req_o[v] && !va_gnt_i[v]) |=> va_req_o[v]);
    assert_stage_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(va_req_o[v] && sa_req_o[v]));
  end
endmodule

bind vcr_input_port vcr_checker #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .flit_valid_i   (flit_valid_i),
  .flit_vc_i      (flit_vc_i),
  .vc_full        (vc_full),
  .va_req_o       (va_req_o),
  .va_gnt_i       (va_gnt_i),
  .sa_req_o       (sa_req_o),
  .sa_gnt_i       (sa_gnt_i),
  .out_valid_o    (out_valid_o),
  .out_type_o     (out_type_o),
  .credit_valid_o (credit_valid_o),
  .vc_free_o      (vc_free_o)
);

// File: tb/vcr_input_port_tb.sv
`timescale 1ns/1ps
module vcr_input_port_tb;
  localparam int NV = 2;
  localparam int FW = 16;
  localparam int HX = 2;
  localparam int HY = 2;
  localparam int ST_IDLE = 0, ST_ROUTE = 1, ST_WAIT = 2, ST_ACT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flit_valid = 1'b0;
  logic [0:0] flit_vc = '0;
  logic [1:0] flit_type = '0;
  logic [FW-1:0] flit_data = '0;
  logic [NV-1:0] va_gnt = '0, sa_gnt = '0;
  logic [0:0] va_ovc = '0;

  logic credit_valid, out_valid, vc_free;
  logic [0:0] credit_vc, out_vc, free_vc;
  logic [NV-1:0] va_req, sa_req;
  logic [3*NV-1:0] req_port;
  logic [2:0] out_port, free_port;
  logic [1:0] out_type;
  logic [FW-1:0] out_data;

  always #5 clk = ~clk;

  vcr_input_port u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .flit_valid_i(flit_valid), .flit_vc_i(flit_vc), .flit_type_i(flit_type), .flit_data_i(flit_data),
    .credit_valid_o(credit_valid), .credit_vc_o(credit_vc),
    .va_req_o(va_req), .va_gnt_i(va_gnt), .va_ovc_i(va_ovc),
    .sa_req_o(sa_req), .sa_gnt_i(sa_gnt), .req_port_o(req_port),
    .out_valid_o(out_valid), .out_port_o(out_port), .out_vc_o(out_vc),
    .out_type_o(out_type), .out_data_o(out_data),
    .vc_free_o(vc_free), .vc_free_port_o(free_port), .vc_free_vc_o(free_vc)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  int m_st [NV];
  int m_port [NV];
  int m_ovc [NV];
  logic [17:0] m_q [NV][$];
  bit e_ov, e_cv, e_fr;
  int e_port, e_vc, e_cvc;
  logic [1:0] e_type;
  logic [FW-1:0] e_data;

  // stimulus state
  logic [17:0] src [NV][$];
  int cred [NV];
  int p_inj = 0, p_va = 0, p_sa = 0, p_junk = 0;
  int lat_in = -1, lat_out = -1;
  bit track = 0;

  function automatic int ref_route(logic [FW-1:0] d);
    int x = int'(d[3:0]);
    int y = int'(d[7:4]);
    if (x > HX) return 2;
    if (x < HX) return 4;
    if (y > HY) return 1;
    if (y < HY) return 3;
    return 0;
  endfunction

  task automatic model_reset();
    for (int v = 0; v < NV; v++) begin
      m_st[v] = ST_IDLE; m_port[v] = 0; m_ovc[v] = 0; m_q[v].delete();
    end
    e_ov = 0; e_cv = 0; e_fr = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) model_reset();
    else begin
      automatic int g = -1;
      automatic logic [17:0] f;
      for (int v = 0; v < NV; v++)
        if (sa_gnt[v] && m_st[v] == ST_ACT && m_q[v].size() > 0) g = v;
      for (int v = 0; v < NV; v++) begin
        case (m_st[v])
          ST_IDLE:  if (m_q[v].size() > 0 && m_q[v][0][16]) m_st[v] = ST_ROUTE;
          ST_ROUTE: begin m_port[v] = ref_route(m_q[v][0][FW-1:0]); m_st[v] = ST_WAIT; end
          ST_WAIT:  if (va_gnt[v]) begin m_ovc[v] = int'(va_ovc); m_st[v] = ST_ACT; end
          default:  if (v == g && m_q[v][0][17]) m_st[v] = ST_IDLE;
        endcase
      end
      e_ov = (g >= 0); e_cv = e_ov; e_fr = 0;
      if (g >= 0) begin
        f = m_q[g].pop_front();
        e_type = f[17:16]; e_data = f[FW-1:0];
        e_port = m_port[g]; e_vc = m_ovc[g]; e_cvc = g;
        e_fr = f[17];
      end
      if (flit_valid) m_q[int'(flit_vc)].push_back({flit_type, flit_data});
    end
  end

  task automatic fail(string req, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
  endtask

  task automatic compare();
    logic [NV-1:0] ev, es;
    for (int v = 0; v < NV; v++) begin
      ev[v] = (m_st[v] == ST_WAIT);
      es[v] = (m_st[v] == ST_ACT) && (m_q[v].size() > 0);
    end
    checks++; if (va_req !== ev) fail("R3", "va_req", int'(va_req), int'(ev));
    checks++; if (sa_req !== es) fail("R4", "sa_req", int'(sa_req), int'(es));
    for (int v = 0; v < NV; v++)
      if (m_st[v] == ST_WAIT || m_st[v] == ST_ACT) begin
        checks++;
        if (int'(req_port[v*3 +: 3]) != m_port[v]) fail("R2", "req_port", int'(req_port[v*3 +: 3]), m_port[v]);
      end
    checks++;
    if (out_valid !== e_ov) fail("R5", "out_valid", int'(out_valid), int'(e_ov));
    else if (e_ov) begin
      if (int'(out_port) != e_port) fail("R2", "out_port", int'(out_port), e_port);
      if (int'(out_vc) != e_vc) fail("R3", "out_vc", int'(out_vc), e_vc);
      if (out_type !== e_type) fail("R5", "out_type", int'(out_type), int'(e_type));
      if (out_data !== e_data) fail("R5", "out_data", int'(out_data), int'(e_data));
    end
    checks++;
    if (credit_valid !== e_cv) fail("R7", "credit_valid", int'(credit_valid), int'(e_cv));
    else if (e_cv && int'(credit_vc) != e_cvc) fail("R7", "credit_vc", int'(credit_vc), e_cvc);
    checks++;
    if (vc_free !== e_fr) fail("R6", "vc_free", int'(vc_free), int'(e_fr));
    else if (e_fr && (int'(free_port) != e_port || int'(free_vc) != e_vc))
      fail("R6", "free_port_vc", int'({free_port, free_vc}), (e_port << 1) | e_vc);
    if (credit_valid) cred[int'(credit_vc)]++;
    if (track && out_valid && out_type == 2'b01 && lat_out < 0) lat_out = cyc;
  endtask

  task automatic drive();
    int s;
    bit sent = 0;
    flit_valid = 0; va_gnt = '0; sa_gnt = '0;
    s = $urandom % NV;
    for (int i = 0; i < NV; i++) begin
      int v = (s + i) % NV;
      if (!sent && src[v].size() > 0 && cred[v] > 0 && ($urandom % 100) < p_inj) begin
        logic [17:0] f = src[v].pop_front();
        sent = 1; cred[v]--;
        flit_valid = 1; flit_vc = 1'(v); flit_type = f[17:16]; flit_data = f[FW-1:0];
        if (track && f[17:16] == 2'b01 && lat_in < 0) lat_in = cyc;
      end
    end
    if (($urandom % 100) < p_va) begin
      s = $urandom % NV;
      for (int i = 0; i < NV; i++) begin
        int v = (s + i) % NV;
        if (va_gnt == '0 && va_req[v]) begin va_gnt[v] = 1; va_ovc = 1'($urandom % 2); end
      end
    end
    if (($urandom % 100) < p_sa) begin
      s = $urandom % NV;
      for (int i = 0; i < NV; i++) begin
        int v = (s + i) % NV;
        if (sa_gnt == '0 && sa_req[v]) sa_gnt[v] = 1;
      end
    end else if (($urandom % 100) < p_junk) begin
      for (int v = 0; v < NV; v++)
        if (sa_gnt == '0 && !sa_req[v]) sa_gnt[v] = 1;  // stray grant, must be ignored (R4)
    end
  endtask

  task automatic run(int n);
    repeat (n) begin @(negedge clk); compare(); drive(); end
  endtask

  task automatic add_pkt(int v, int dx, int dy, int nbody, bit single);
    logic [FW-1:0] hdr = {8'($urandom), 4'(dy), 4'(dx)};
    if (single) src[v].push_back({2'b11, hdr});
    else begin
      src[v].push_back({2'b01, hdr});
      for (int b = 0; b < nbody; b++) src[v].push_back({2'b00, 16'($urandom)});
      src[v].push_back({2'b10, 16'($urandom)});
    end
  endtask

  function automatic bit all_idle();
    for (int v = 0; v < NV; v++)
      if (src[v].size() > 0 || m_q[v].size() > 0 || m_st[v] != ST_IDLE) return 0;
    return 1;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(7));
    for (int v = 0; v < NV; v++) cred[v] = 4;
    model_reset();
    repeat (2) @(negedge clk);
    // R8: reset values
    checks++;
    if ({va_req, sa_req, out_valid, credit_valid, vc_free} !== '0)
      fail("R8", "reset outputs", int'({va_req, sa_req, out_valid, credit_valid, vc_free}), 0);
    rst_n = 1;

    // R1: lone packet, eager grants
    p_inj = 100; p_va = 100; p_sa = 100; track = 1;
    add_pkt(0, 5, 2, 2, 0);
    run(20);
    track = 0;
    checks++;
    if (lat_out - lat_in != 5) fail("R1", "head latency", lat_out - lat_in, 5);

    // R2 / R6: single-flit packets toward each port
    add_pkt(1, 2, 2, 0, 1);
    add_pkt(1, 2, 7, 0, 1);
    add_pkt(1, 9, 2, 0, 1);
    add_pkt(1, 2, 0, 0, 1);
    add_pkt(1, 0, 2, 0, 1);
    add_pkt(1, 0, 9, 0, 1);
    run(50);

    // R4 / R7 / R9: withhold switch grants until queues fill
    add_pkt(0, 7, 1, 4, 0);
    add_pkt(1, 1, 1, 4, 0);
    p_sa = 0;
    run(30);
    for (int v = 0; v < NV; v++) begin
      checks++;
      if (cred[v] != 0) fail("R9", "credits with full buffer", cred[v], 0);
    end
    p_sa = 100;
    run(40);

    // mixed traffic
    for (int k = 0; k < 150; k++)
      add_pkt($urandom % NV, $urandom % 8, $urandom % 8, $urandom % 4, ($urandom % 4) == 0);
    p_inj = 70; p_va = 50; p_sa = 60; p_junk = 30;
    for (int k = 0; k < 20000 && !all_idle(); k++) run(1);
    p_sa = 100; p_va = 100; p_junk = 0;
    run(20);
    checks++;
    if (!all_idle()) fail("R5", "traffic drained", 0, 1);
    for (int v = 0; v < NV; v++) begin
      checks++;
      if (cred[v] != 4) fail("R7", "credits returned", cred[v], 4);
    end
    summary();
  end
endmodule